// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block carries out the write-type commands of a serial flash device once the serial front end has shifted them in completely. The front end raises `cmd_valid` for a single clock when chip select rises after a full instruction. That pulse comes with the opcode, the target address and the data byte. The sequencer owns the write-enable latch and the auto-increment programming flag. It checks every program or erase target against the two block-protect bits. It also models a self-timed operation by holding `busy` for a parameterised number of clock cycles.

The array is a small internal byte array that resets to the erased value FFh. Programming clears bits only: the new byte is the old byte ANDed with the data. Erase sets a sector, a block or the whole array back to FFh. The front end reads the array through a combinational read port. A change to the array becomes visible when the timed operation completes. Status register writes and serial shifting are handled elsewhere.

Top module: `flash_seq`

## Requirements
- R1: After reset `busy`, `write_en` and `aai_mode` are 0 and every array byte reads FFh.
- R2: A command takes effect only in a cycle where `cmd_valid` is 1. Any command that arrives while `busy` is 1 has no effect.
- R3: Opcode 06h sets `write_en`. Opcode 04h clears both `write_en` and `aai_mode`.
- R4: Opcodes 02h, 20h, 52h, 60h and AFh are ignored when `write_en` is 0. An ignored command raises no `busy` and changes no array byte.
- R5: Opcode 02h ANDs `cmd_data` into the byte at `cmd_addr`. `busy` stays high for exactly T_PROG cycles, and `write_en` clears when the operation completes.
- R6: Opcode 20h sets to FFh every byte whose address bits above SECT_W match `cmd_addr`, taking T_SECT cycles. Opcode 52h does the same with BLK_W, taking T_BLK cycles. Both clear `write_en` on completion.
- R7: Opcode 60h sets all bytes to FFh in T_CHIP cycles. It is ignored unless `bp` is 00.
- R8: `bp` selects the protected region by the two top address bits: 00 protects nothing, 01 the top quarter (11), 10 the top half (1x), 11 everything. A program, erase or AAI byte whose target lies in that region is ignored.
- R9: In the idle state, opcode AFh programs `cmd_data` at `cmd_addr` and sets `aai_mode`. While `aai_mode` is 1, each AFh programs the address after the last one written and ignores `cmd_addr`. `write_en` stays 1 between these bytes.
- R10: AAI never wraps. Completing the byte at the highest address clears `aai_mode` and `write_en`. A continuation byte whose next address is protected is ignored, and `aai_mode` stays 1.
- R11: While `aai_mode` is 1, opcodes 02h, 20h, 52h and 60h are ignored.
- R12: During `busy` the read port still shows the old contents. The new contents appear in the first cycle in which `busy` is 0.
- R13: Opcodes other than 02h, 04h, 06h, 20h, 52h, 60h and AFh have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: a complete instruction ended with chip select rising |
| cmd_op | input | 8 | Opcode of the instruction |
| cmd_addr | input | ADDR_W | Target byte address (low bits of the serial address) |
| cmd_data | input | 8 | Data byte for program commands |
| bp | input | 2 | Block-protect bits from the status register |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Self-timed operation in progress |
| write_en | output | 1 | Write-enable latch |
| aai_mode | output | 1 | Auto-increment programming mode active |

## Verification
The assertions assume that `cmd_valid` is a clean pulse with a known opcode and that `bp` is known on every clock after reset. The bench meets this by driving all inputs at the falling edge. It pulses `cmd_valid` for exactly one cycle and changes `bp` only while the sequencer is idle. The stimulus also sends commands during `busy` on purpose, because the assertions and the reference model both treat those commands as no-ops.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_SECT  = 8'h20;
    localparam logic [7:0] OP_BLK   = 8'h52;
    localparam logic [7:0] OP_CHIP  = 8'h60;
    localparam logic [7:0] OP_AAI   = 8'hAF;

    typedef enum logic [1:0] {
        JOB_PROG = 2'd0,
        JOB_SECT = 2'd1,
        JOB_BLK  = 2'd2,
        JOB_CHIP = 2'd3
    } job_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLR   = 2'd2,
        ACT_START = 2'd3
    } act_e;

    typedef struct packed {
        act_e act;
        job_e kind;
        logic aai_job;
    } dec_t;

    // Protection from the two top address bits.
    function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 4,
    parameter int BLK_W  = 6
) (
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              busy,
    input  logic              wel,
    input  logic              aai,
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] last_addr,
    output dec_t              dec,
    output logic [ADDR_W-1:0] tgt
);
    localparam logic [ADDR_W-1:0] S_MASK = ADDR_W'((1 << SECT_W) - 1);
    localparam logic [ADDR_W-1:0] B_MASK = ADDR_W'((1 << BLK_W) - 1);

    logic [ADDR_W-1:0] nxt;
    logic              may_wr;

    assign nxt    = last_addr + ADDR_W'(1);
    assign may_wr = wel && !aai;

    always_comb begin
        dec = '{act: ACT_NONE, kind: JOB_PROG, aai_job: 1'b0};
        tgt = cmd_addr;
        if (cmd_valid && !busy) begin
            case (cmd_op)
                OP_WREN: dec.act = ACT_SET;
                OP_WRDI: dec.act = ACT_CLR;
                OP_PROG: begin
                    if (may_wr && !prot_hit(bp, cmd_addr[ADDR_W-1 -: 2]))
                        dec.act = ACT_START;
                end
                OP_SECT: begin
                    tgt      = cmd_addr & ~S_MASK;
                    dec.kind = JOB_SECT;
                    if (may_wr && !prot_hit(bp, tgt[ADDR_W-1 -: 2]))
                        dec.act = ACT_START;
                end
                OP_BLK: begin
                    tgt      = cmd_addr & ~B_MASK;
                    dec.kind = JOB_BLK;
                    if (may_wr && !prot_hit(bp, tgt[ADDR_W-1 -: 2]))
                        dec.act = ACT_START;
                end
                OP_CHIP: begin
                    dec.kind = JOB_CHIP;
                    if (may_wr && bp == 2'b00)
                        dec.act = ACT_START;
                end
                OP_AAI: begin
                    dec.aai_job = 1'b1;
                    if (aai) begin
                        tgt = nxt;
                        if (!prot_hit(bp, nxt[ADDR_W-1 -: 2]))
                            dec.act = ACT_START;
                    end else if (wel && !prot_hit(bp, cmd_addr[ADDR_W-1 -: 2])) begin
                        dec.act = ACT_START;
                    end
                end
                default: dec.act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= len - CW'(1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 4,
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  job_e              upd_kind,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [7:0]        upd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic hit;

        always_comb begin
            case (upd_kind)
                JOB_PROG: hit = (upd_addr == IDX);
                JOB_SECT: hit = ((upd_addr >> SECT_W) == (IDX >> SECT_W));
                JOB_BLK:  hit = ((upd_addr >> BLK_W) == (IDX >> BLK_W));
                default:  hit = 1'b1;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= 8'hFF;
            else if (upd_en && hit)
                mem[i] <= (upd_kind == JOB_PROG) ? (mem[i] & upd_data) : 8'hFF;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 4,
    parameter int BLK_W  = 6,
    parameter int T_PROG = 4,
    parameter int T_SECT = 8,
    parameter int T_BLK  = 12,
    parameter int T_CHIP = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              write_en,
    output logic              aai_mode
);
    localparam int T_M1 = (T_PROG > T_SECT) ? T_PROG : T_SECT;
    localparam int T_M2 = (T_BLK > T_CHIP) ? T_BLK : T_CHIP;
    localparam int TMAX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [ADDR_W-1:0] TOP = '1;

    dec_t              dec;
    logic [ADDR_W-1:0] tgt;
    logic              done;
    logic [CW-1:0]     len;

    job_e              job_kind;
    logic [ADDR_W-1:0] job_addr;
    logic [7:0]        job_data;
    logic              job_aai;

    flash_seq_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .busy      (busy),
        .wel       (write_en),
        .aai       (aai_mode),
        .bp        (bp),
        .last_addr (job_addr),
        .dec       (dec),
        .tgt       (tgt)
    );

    always_comb begin
        case (dec.kind)
            JOB_PROG: len = CW'(T_PROG);
            JOB_SECT: len = CW'(T_SECT);
            JOB_BLK:  len = CW'(T_BLK);
            default:  len = CW'(T_CHIP);
        endcase
    end

    flash_seq_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (dec.act == ACT_START),
        .len   (len),
        .busy  (busy),
        .done  (done)
    );

    flash_seq_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (done),
        .upd_kind (job_kind),
        .upd_addr (job_addr),
        .upd_data (job_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            write_en <= 1'b0;
            aai_mode <= 1'b0;
            job_kind <= JOB_PROG;
            job_addr <= '0;
            job_data <= '0;
            job_aai  <= 1'b0;
        end else begin
            if (done) begin
                if (!job_aai) begin
                    write_en <= 1'b0;
                end else if (job_addr == TOP) begin
                    write_en <= 1'b0;
                    aai_mode <= 1'b0;
                end
            end
            case (dec.act)
                ACT_SET: write_en <= 1'b1;
                ACT_CLR: begin
                    write_en <= 1'b0;
                    aai_mode <= 1'b0;
                end
                ACT_START: begin
                    job_kind <= dec.kind;
                    job_addr <= tgt;
                    job_data <= cmd_data;
                    job_aai  <= dec.aai_job;
                    if (dec.aai_job)
                        aai_mode <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int T_MAX = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic [1:0] bp,
    input logic       busy,
    input logic       write_en,
    input logic       aai_mode
);
    int unsigned run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= 0;
        else              run_cnt <= run_cnt + 1;
    end

    // R2: no operation starts without a command pulse
    p_start_needs_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !$rose(busy));

    // R2: latch and mode are frozen while an operation is running
    p_busy_freezes_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(write_en) && $stable(aai_mode)));

    p_wren_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 8'h06) |=> write_en);

    p_wrdi_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 8'h04) |=> (!write_en && !aai_mode));

    p_start_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(write_en));

    p_busy_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < T_MAX));

    p_chip_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 8'h60 && bp != 2'b00) |=> !busy);

    p_aai_has_wel_r9: assert property (@(posedge clk) disable iff (rst)
        aai_mode |-> write_en);
endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .bp        (bp),
    .busy      (busy),
    .write_en  (write_en),
    .aai_mode  (aai_mode)
);

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int TP = 4, TS = 8, TB = 12, TC = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic [1:0]    bp = 2'b00;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy, write_en, aai_mode;

    int vec = 0;
    int bad = 0;

    logic [7:0] em [DEPTH];
    bit ewel = 0, eaai = 0;
    int elast = 0;

    always #2.5 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .SECT_W(4), .BLK_W(6),
                .T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .bp(bp), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .write_en(write_en), .aai_mode(aai_mode)
    );

    function automatic bit prot(input logic [1:0] b, input int a);
        case (b)
            2'b00:   return 1'b0;
            2'b01:   return a >= 192;
            2'b10:   return a >= 128;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int errs = 0, fa = 0, fe = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #0.01;
            if (rd_data !== em[a]) begin
                if (errs == 0) begin fa = rd_data; fe = em[a]; end
                errs++;
            end
        end
        chk(errs == 0, req, fa, fe);
        @(negedge clk);
    endtask

    task automatic issue(input logic [7:0] op, input int a_in, input logic [7:0] d, input logic [7:0] inj);
        int a = a_in & (DEPTH - 1);
        int tgt = a, lo = 0, hi = -1, dur = 0, n = 0;
        bit start = 0, aaijob = 0, prg = 0;
        string req = "R13";
        case (op)
            8'h06: req = "R3";
            8'h04: req = "R3";
            8'h02: begin
                prg = 1; dur = TP; req = "R5";
                if (eaai) req = "R11"; else if (!ewel) req = "R4";
                else if (prot(bp, a)) req = "R8"; else start = 1;
            end
            8'h20, 8'h52: begin
                tgt = (op == 8'h20) ? (a & ~15) : (a & ~63);
                lo = tgt; hi = tgt + ((op == 8'h20) ? 15 : 63);
                dur = (op == 8'h20) ? TS : TB; req = "R6";
                if (eaai) req = "R11"; else if (!ewel) req = "R4";
                else if (prot(bp, tgt)) req = "R8"; else start = 1;
            end
            8'h60: begin
                lo = 0; hi = DEPTH - 1; dur = TC; req = "R7";
                if (eaai) req = "R11"; else if (!ewel) req = "R4";
                else if (bp != 2'b00) req = "R7"; else start = 1;
            end
            8'hAF: begin
                prg = 1; aaijob = 1; dur = TP; req = "R9";
                if (eaai) begin
                    tgt = elast + 1;
                    if (prot(bp, tgt)) req = "R10"; else start = 1;
                end else if (!ewel) req = "R4";
                else if (prot(bp, a)) req = "R8"; else start = 1;
            end
            default: ;
        endcase

        @(negedge clk);
        cmd_op = op; cmd_addr = AW'(a); cmd_data = d; cmd_valid = 1'b1;
        rd_addr = AW'(tgt);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === start, req, busy, start);
        if (start) begin
            if (aaijob) eaai = 1;
            chk(rd_data === em[tgt], "R12", rd_data, em[tgt]);
            while (busy && n < 200) begin
                if (n == 0 && inj != 8'h00) begin
                    cmd_op = inj; cmd_addr = AW'($urandom % DEPTH); cmd_valid = 1'b1;
                end else begin
                    cmd_valid = 1'b0;
                end
                n++;
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            chk(n == dur, req, n, dur);
            if (prg) em[tgt] = em[tgt] & d;
            else for (int i = lo; i <= hi; i++) em[i] = 8'hFF;
            if (!aaijob) ewel = 0;
            else begin
                elast = tgt;
                if (tgt == DEPTH - 1) begin ewel = 0; eaai = 0; end
            end
            chk(rd_data === em[tgt], "R12", rd_data, em[tgt]);
        end else begin
            if (op == 8'h06) ewel = 1;
            if (op == 8'h04) begin ewel = 0; eaai = 0; end
        end
        chk(write_en === ewel, req, write_en, ewel);
        chk(aai_mode === eaai, req, aai_mode, eaai);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [7:0] ops [10];
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) em[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", busy, 0);
        chk(write_en === 1'b0, "R1", write_en, 0);
        chk(aai_mode === 1'b0, "R1", aai_mode, 0);
        check_mem("R1");

        // R4: program without latch
        issue(8'h02, 5, 8'h00, 8'h00);
        // R5: program then AND
        issue(8'h06, 0, 0, 0);
        issue(8'h02, 5, 8'h5A, 0);
        issue(8'h06, 0, 0, 0);
        issue(8'h02, 5, 8'h0F, 0);
        issue(8'h06, 0, 0, 0);
        issue(8'h02, 70, 8'h00, 0);
        // R6: sector and block erase
        issue(8'h06, 0, 0, 0);
        issue(8'h20, 7, 0, 0);
        issue(8'h06, 0, 0, 0);
        issue(8'h52, 100, 0, 0);
        // R7: chip erase locked, then allowed
        bp = 2'b01;
        issue(8'h06, 0, 0, 0);
        issue(8'h60, 0, 0, 0);
        bp = 2'b00;
        issue(8'h60, 0, 0, 0);
        // R8: half protected
        bp = 2'b10;
        issue(8'h06, 0, 0, 0);
        issue(8'h02, 8'h90, 8'h00, 0);
        issue(8'h02, 8'h10, 8'h33, 0);
        // R9 R10: AAI reaches the top, WRDI during busy ignored (R2)
        bp = 2'b00;
        issue(8'h06, 0, 0, 0);
        issue(8'hAF, 253, 8'h11, 0);
        issue(8'hAF, 3, 8'h22, 8'h04);
        issue(8'hAF, 9, 8'h44, 0);
        // R10: continuation into protected area; R11 during AAI
        bp = 2'b01;
        issue(8'h06, 0, 0, 0);
        issue(8'hAF, 190, 8'hA5, 0);
        issue(8'hAF, 0, 8'h5A, 0);
        issue(8'hAF, 0, 8'h00, 0);
        issue(8'h02, 20, 8'h00, 0);
        issue(8'h20, 20, 8'h00, 0);
        issue(8'h04, 0, 0, 0);
        // R13: unknown opcodes
        issue(8'h9F, 1, 0, 0);
        issue(8'h05, 1, 0, 0);
        check_mem("R12");

        ops = '{8'h02, 8'h20, 8'h52, 8'h60, 8'hAF, 8'h06, 8'h06, 8'h04, 8'h05, 8'hC7};
        for (int it = 0; it < 500; it++) begin
            logic [7:0] op, inj;
            op = ops[$urandom % 10];
            if (eaai && ($urandom % 10) < 7) op = 8'hAF;
            if (($urandom % 10) == 0) bp = 2'($urandom % 4);
            inj = (($urandom % 8) == 0) ? ops[$urandom % 10] : 8'h00;
            issue(op, int'($urandom % DEPTH), 8'($urandom), inj);
            if (it % 50 == 49) check_mem("R5");
        end
        check_mem("R6");

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule